// File: doc/BRIEF.md
# Parallel Flash Bus Latch Front End

This block sits on the device side of a parallel flash-style bus and turns raw pin activity into clean, clock-synchronous events for the logic behind it. All bus pins go through a synchronizer first. A rising edge of the write strobe then becomes one of three things. With the command enable high it is a command strobe. With the address enable high it is an address byte, shifted into an assembled address word. With both enables low it is a data word. A falling edge of the read strobe loads the word the array offers for the current column into the output register and advances the column counter.

A small state machine governs the block. `ST_IDLE` is standby while the chip is deselected. `ST_ACTIVE` is the selected, ready state, in which transfers are accepted. `ST_BUSY` is entered when a program, erase or read-start command is taken, and it holds the ready/busy output low for a programmable number of clock cycles. The transitions are:
- `SELECT`: IDLE to ACTIVE, when chip enable goes low.
- `DESELECT`: ACTIVE to IDLE, when chip enable goes high.
- `START`: ACTIVE to BUSY, when a busy-starting command is accepted.
- `RESUME`: BUSY to ACTIVE, when the timer expires with chip enable low.
- `RETIRE`: BUSY to IDLE, when the timer expires with chip enable high.

While the write-protect pin is low, program and erase commands are dropped. A write strobe with both enables high is illegal. It is discarded, and it sets a sticky protocol error flag.

Top module: `nand_bus_front`

## Requirements
- R1: A write-strobe rising edge with command enable high and address enable low, while ACTIVE, gives a one-cycle `cmd_stb`. It also sets `cmd_code` to bus bits 7..0; bits 15..8 are ignored.
- R2: The first address cycle after a command, or after reset, puts its byte (bits 7..0) in byte 0 of `addr`, clears the other bytes and sets `addr_cnt` to 1. Each later address cycle fills the next byte position upward. Cycles beyond `ADDR_BYTES` bytes leave `addr` unchanged.
- R3: A write-strobe rising edge with both enables low, while ACTIVE, gives a one-cycle `wr_stb`, with `wr_data` holding the full bus word.
- R4: A read-strobe falling edge while ACTIVE loads `io_out` with `rd_data` for the current `col`, then increments `col` by one.
- R5: Every accepted command cycle clears `col` to zero.
- R6: `io_oe` is 1 only while the block is ACTIVE, selected and the read strobe is low; otherwise it is 0 (bus released).
- R7: Accepting command code 0x10 (program), 0xD0 (erase) or 0x30 (read start) drives `rb_n` low for exactly `BUSY_CYCLES` clock cycles, starting in the cycle `cmd_stb` is high.
- R8: While busy, write- and read-strobe edges are ignored, and chip enable going high does not shorten the busy period. If chip enable is high when busy ends, the block goes to standby.
- R9: While `wp_n` is low, codes 0x10 and 0xD0 are dropped: no `cmd_stb` and no busy. Code 0x30 is still accepted.
- R10: A write-strobe rising edge with both enables high produces no strobe and leaves `addr` unchanged. It sets `proto_err`, which stays 1 until reset.
- R11: While chip enable is high, and not busy, write- and read-strobe edges have no effect.
- R12: After reset: `rb_n`=1, `io_oe`=0, `addr`=0, `addr_cnt`=0, `col`=0, `proto_err`=0, and no strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| cle | input | 1 | Command latch enable |
| ale | input | 1 | Address latch enable |
| we_n | input | 1 | Write strobe, sampled on its rising edge |
| re_n | input | 1 | Read strobe, acts on its falling edge |
| wp_n | input | 1 | Write protect, active low |
| io_in | input | BUS_W | Bus value from the pins |
| io_out | output | BUS_W | Read word to drive onto the bus |
| io_oe | output | 1 | Bus output enable (0 = high impedance) |
| rb_n | output | 1 | Ready (1) / busy (0), always driven |
| cmd_stb | output | 1 | One-cycle command strobe |
| cmd_code | output | 8 | Last accepted command byte |
| addr | output | 8*ADDR_BYTES | Assembled address |
| addr_cnt | output | $clog2(ADDR_BYTES+1) | Address bytes held |
| wr_stb | output | 1 | One-cycle data-in strobe |
| wr_data | output | BUS_W | Data-in word |
| rd_data | input | BUS_W | Array word for the current column |
| col | output | COL_W | Column counter |
| proto_err | output | 1 | Sticky illegal-cycle flag |

## Verification
With `SYNC_STAGES` = 2, a pin change reaches the synchronized copy at the second rising clock edge. Strobes, registers, `io_oe` and the state change at the third edge. Each bench task therefore holds a pin level for four clock cycles and samples on the falling edge after that, so every result has settled before it is read. One-cycle strobes and busy time are counted by a falling-edge monitor, and the busy length is compared against `BUSY_CYCLES` once `rb_n` has risen.

// File: rtl/nbf_pkg.sv
package nbf_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACTIVE = 2'd1,
        ST_BUSY   = 2'd2
    } fe_state_t;

    localparam int CMD_W  = 8;
    localparam int BYTE_W = 8;
endpackage

// File: rtl/nbf_sync.sv
module nbf_sync #(
    parameter int W = 8,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) pipe[0] <= RST_VAL;
                    else        pipe[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) pipe[g] <= RST_VAL;
                    else        pipe[g] <= pipe[g-1];
                end
            end
        end
    endgenerate

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/nbf_addr.sv
module nbf_addr import nbf_pkg::*; #(
    parameter int NB = 4,
    localparam int CW = $clog2(NB + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_cyc,
    input  logic                 addr_cyc,
    input  logic [BYTE_W-1:0]    byte_in,
    output logic [NB*BYTE_W-1:0] addr,
    output logic [CW-1:0]        cnt
);
    logic new_seq;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr    <= '0;
            cnt     <= '0;
            new_seq <= 1'b1;
        end else if (cmd_cyc) begin
            new_seq <= 1'b1;
        end else if (addr_cyc) begin
            if (new_seq) begin
                addr    <= {{(NB-1)*BYTE_W{1'b0}}, byte_in};
                cnt     <= CW'(1);
                new_seq <= 1'b0;
            end else if (32'(cnt) < NB) begin
                for (int i = 0; i < NB; i++) begin
                    if (32'(cnt) == i) addr[i*BYTE_W +: BYTE_W] <= byte_in;
                end
                cnt <= cnt + CW'(1);
            end
        end
    end

    // R2: the byte count never passes the address width
    a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        32'(cnt) <= NB);

    // R2: an address cycle that opens a sequence restarts the count at one
    a_r2_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_cyc && !cmd_cyc && new_seq) |=> (cnt == CW'(1)));
endmodule

// File: rtl/nbf_busy.sv
module nbf_busy #(
    parameter int CW = 16,
    parameter int CYCLES = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done
);
    logic [CW-1:0] cnt;
    logic          running;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            running <= 1'b0;
        end else if (start) begin
            cnt     <= CW'(CYCLES - 1);
            running <= 1'b1;
        end else if (running) begin
            if (cnt == '0) running <= 1'b0;
            else           cnt     <= cnt - CW'(1);
        end
    end

    assign done = running && (cnt == '0);

    // R7: the timer stops only after counting down to zero
    a_r7_no_early_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !start) |=> (running || $past(cnt) == '0));
endmodule

// File: rtl/nand_bus_front.sv
module nand_bus_front import nbf_pkg::*; #(
    parameter int BUS_W       = 16,
    parameter int ADDR_BYTES  = 4,
    parameter int COL_W       = 12,
    parameter int SYNC_STAGES = 2,
    parameter int BUSY_W      = 16,
    parameter int BUSY_CYCLES = 20,
    parameter logic [7:0] CODE_PROG  = 8'h10,
    parameter logic [7:0] CODE_ERASE = 8'hD0,
    parameter logic [7:0] CODE_RDST  = 8'h30
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          ce_n,
    input  logic                          cle,
    input  logic                          ale,
    input  logic                          we_n,
    input  logic                          re_n,
    input  logic                          wp_n,
    input  logic [BUS_W-1:0]              io_in,
    output logic [BUS_W-1:0]              io_out,
    output logic                          io_oe,
    output logic                          rb_n,
    output logic                          cmd_stb,
    output logic [7:0]                    cmd_code,
    output logic [8*ADDR_BYTES-1:0]       addr,
    output logic [$clog2(ADDR_BYTES+1)-1:0] addr_cnt,
    output logic                          wr_stb,
    output logic [BUS_W-1:0]              wr_data,
    input  logic [BUS_W-1:0]              rd_data,
    output logic [COL_W-1:0]              col,
    output logic                          proto_err
);
    localparam int WP_B  = BUS_W;
    localparam int RE_B  = BUS_W + 1;
    localparam int WE_B  = BUS_W + 2;
    localparam int ALE_B = BUS_W + 3;
    localparam int CLE_B = BUS_W + 4;
    localparam int CE_B  = BUS_W + 5;
    localparam int PW    = BUS_W + 6;
    localparam logic [PW-1:0] PIN_RST =
        {1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, {BUS_W{1'b0}}};

    logic [PW-1:0] pins_s;
    logic          we_d, re_d;
    fe_state_t     state, nxt;

    nbf_sync #(.W(PW), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ce_n, cle, ale, we_n, re_n, wp_n, io_in}),
        .q     (pins_s)
    );

    logic ce_s, cle_s, ale_s, we_s, re_s, wp_s;
    logic [BUS_W-1:0]  io_s;
    logic [CMD_W-1:0]  lo_s;
    assign ce_s  = pins_s[CE_B];
    assign cle_s = pins_s[CLE_B];
    assign ale_s = pins_s[ALE_B];
    assign we_s  = pins_s[WE_B];
    assign re_s  = pins_s[RE_B];
    assign wp_s  = pins_s[WP_B];
    assign io_s  = pins_s[BUS_W-1:0];
    assign lo_s  = io_s[CMD_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_d <= 1'b1;
            re_d <= 1'b1;
        end else begin
            we_d <= we_s;
            re_d <= re_s;
        end
    end

    logic we_rise, re_fall, xfer_ok;
    logic cmd_cyc, addr_cyc, data_cyc, bad_cyc;
    logic blocked, cmd_ok, start_busy, busy_done;

    assign we_rise  = we_s && !we_d;
    assign re_fall  = !re_s && re_d;
    assign xfer_ok  = (state == ST_ACTIVE) && !ce_s;
    assign bad_cyc  = xfer_ok && we_rise && cle_s && ale_s;
    assign cmd_cyc  = xfer_ok && we_rise && cle_s && !ale_s;
    assign addr_cyc = xfer_ok && we_rise && ale_s && !cle_s;
    assign data_cyc = xfer_ok && we_rise && !cle_s && !ale_s;
    assign blocked  = !wp_s && (lo_s == CODE_PROG || lo_s == CODE_ERASE);
    assign cmd_ok   = cmd_cyc && !blocked;
    assign start_busy = cmd_ok &&
        (lo_s == CODE_PROG || lo_s == CODE_ERASE || lo_s == CODE_RDST);

    nbf_busy #(.CW(BUSY_W), .CYCLES(BUSY_CYCLES)) u_busy (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start_busy),
        .done  (busy_done)
    );

    nbf_addr #(.NB(ADDR_BYTES)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_cyc  (cmd_ok),
        .addr_cyc (addr_cyc),
        .byte_in  (lo_s),
        .addr     (addr),
        .cnt      (addr_cnt)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next state: SELECT, DESELECT, START, RESUME, RETIRE
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (!ce_s) nxt = ST_ACTIVE;
            ST_ACTIVE: begin
                if (ce_s)            nxt = ST_IDLE;
                else if (start_busy) nxt = ST_BUSY;
            end
            ST_BUSY:   if (busy_done) nxt = ce_s ? ST_IDLE : ST_ACTIVE;
            default:   nxt = ST_IDLE;
        endcase
    end

    assign rb_n = (state != ST_BUSY);

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_stb   <= 1'b0;
            cmd_code  <= '0;
            wr_stb    <= 1'b0;
            wr_data   <= '0;
            io_out    <= '0;
            io_oe     <= 1'b0;
            col       <= '0;
            proto_err <= 1'b0;
        end else begin
            cmd_stb <= cmd_ok;
            wr_stb  <= data_cyc;
            io_oe   <= (nxt == ST_ACTIVE) && !ce_s && !re_s;
            if (bad_cyc)  proto_err <= 1'b1;
            if (cmd_ok) begin
                cmd_code <= lo_s;
                col      <= '0;
            end
            if (data_cyc) wr_data <= io_s;
            if (xfer_ok && re_fall && !cmd_ok) begin
                io_out <= rd_data;
                col    <= col + COL_W'(1);
            end
        end
    end

    // R4: each accepted read edge steps the column by one
    a_r4_col_step: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_ok && re_fall && !we_rise) |=> (col == $past(col) + COL_W'(1)));

    // R6: the bus is never driven while busy
    a_r6_no_drive_busy: assert property (@(posedge clk) disable iff (!rst_n)
        io_oe |-> rb_n);

    // R7: busy can only begin together with an accepted command
    a_r7_busy_with_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rb_n) |-> cmd_stb);

    // R8: busy persists until the timer ends, whatever chip enable does
    a_r8_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!rb_n && !busy_done) |=> !rb_n);

    // R10: an illegal cycle leaves no strobe and no address change
    a_r10_bad_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        bad_cyc |=> (proto_err && !cmd_stb && !wr_stb && $stable(addr)));

    // R10: the error flag is sticky
    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |=> proto_err);
endmodule

// File: tb/nand_bus_front_tb.sv
module nand_bus_front_tb;
    localparam int BUS_W = 16;
    localparam int NB    = 4;
    localparam int COL_W = 12;
    localparam int BUSY  = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_n = 1'b1, cle = 1'b0, ale = 1'b0, we_n = 1'b1, re_n = 1'b1, wp_n = 1'b1;
    logic [BUS_W-1:0] io_in = '0;
    logic [BUS_W-1:0] io_out, wr_data, rd_data;
    logic io_oe, rb_n, cmd_stb, wr_stb, proto_err;
    logic [7:0] cmd_code;
    logic [8*NB-1:0] addr;
    logic [$clog2(NB+1)-1:0] addr_cnt;
    logic [COL_W-1:0] col;

    always #10 clk = ~clk;

    assign rd_data = {4'hA, col};

    nand_bus_front #(.BUS_W(BUS_W), .ADDR_BYTES(NB), .COL_W(COL_W),
                     .BUSY_CYCLES(BUSY)) u_dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale),
        .we_n(we_n), .re_n(re_n), .wp_n(wp_n), .io_in(io_in),
        .io_out(io_out), .io_oe(io_oe), .rb_n(rb_n), .cmd_stb(cmd_stb),
        .cmd_code(cmd_code), .addr(addr), .addr_cnt(addr_cnt),
        .wr_stb(wr_stb), .wr_data(wr_data), .rd_data(rd_data),
        .col(col), .proto_err(proto_err));

    int n_chk = 0, n_fail = 0;
    int cmd_cnt = 0, wr_cnt = 0, busy_len = 0, cyc = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (cmd_stb) cmd_cnt++;
            if (wr_stb)  wr_cnt++;
            if (!rb_n)   busy_len++;
        end
        cyc++;
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wcycle(input logic c, input logic a, input logic [BUS_W-1:0] v);
        @(negedge clk);
        cle = c; ale = a; io_in = v; we_n = 1'b0;
        idle(4);
        we_n = 1'b1;
        idle(4);
        cle = 1'b0; ale = 1'b0;
    endtask

    task automatic rpulse(output logic [BUS_W-1:0] d, output logic oe);
        @(negedge clk);
        re_n = 1'b0;
        idle(4);
        d = io_out; oe = io_oe;
        re_n = 1'b1;
        idle(4);
    endtask

    task automatic wait_ready();
        for (int i = 0; i < 300 && !rb_n; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R12 rb_n", 64'(rb_n), 64'd1);
        chk("R12 io_oe", 64'(io_oe), 64'd0);
        chk("R12 addr", 64'(addr), 64'd0);
        chk("R12 addr_cnt", 64'(addr_cnt), 64'd0);
        chk("R12 col", 64'(col), 64'd0);
        chk("R12 proto_err", 64'(proto_err), 64'd0);
        chk("R12 strobes", 64'(cmd_cnt + wr_cnt), 64'd0);
    endtask

    task automatic t_cmd();
        int c0 = cmd_cnt;
        ce_n = 1'b0; idle(4);
        wcycle(1'b1, 1'b0, 16'h5A3C);
        chk("R1 strobe count", 64'(cmd_cnt - c0), 64'd1);
        chk("R1 low byte only", 64'(cmd_code), 64'h3C);
        chk("R1 no busy", 64'(rb_n), 64'd1);
    endtask

    task automatic t_addr();
        wcycle(1'b0, 1'b1, 16'hFF11);
        wcycle(1'b0, 1'b1, 16'h0022);
        wcycle(1'b0, 1'b1, 16'h0033);
        chk("R2 partial addr", 64'(addr), 64'h00332211);
        chk("R2 partial cnt", 64'(addr_cnt), 64'd3);
        wcycle(1'b0, 1'b1, 16'h0044);
        wcycle(1'b0, 1'b1, 16'h0055);
        chk("R2 overflow ignored", 64'(addr), 64'h44332211);
        chk("R2 full cnt", 64'(addr_cnt), 64'd4);
        wcycle(1'b1, 1'b0, 16'h0005);
        wcycle(1'b0, 1'b1, 16'h0077);
        chk("R2 restart addr", 64'(addr), 64'h00000077);
        chk("R2 restart cnt", 64'(addr_cnt), 64'd1);
    endtask

    task automatic t_data();
        int w0 = wr_cnt;
        wcycle(1'b0, 1'b0, 16'hBEEF);
        chk("R3 strobe count", 64'(wr_cnt - w0), 64'd1);
        chk("R3 full word", 64'(wr_data), 64'hBEEF);
    endtask

    task automatic t_read();
        logic [BUS_W-1:0] d;
        logic oe;
        wcycle(1'b1, 1'b0, 16'h0000);
        chk("R5 col cleared", 64'(col), 64'd0);
        for (int i = 0; i < 3; i++) begin
            rpulse(d, oe);
            chk("R4 read word", 64'(d), 64'(16'hA000 + i));
            chk("R6 oe while low", 64'(oe), 64'd1);
        end
        chk("R4 col advanced", 64'(col), 64'd3);
        chk("R6 oe released", 64'(io_oe), 64'd0);
        wcycle(1'b1, 1'b0, 16'h0000);
        chk("R5 col cleared again", 64'(col), 64'd0);
    endtask

    task automatic t_deselect();
        logic [BUS_W-1:0] d;
        logic oe;
        int c0 = cmd_cnt;
        ce_n = 1'b1; idle(4);
        wcycle(1'b1, 1'b0, 16'h0077);
        chk("R11 cmd ignored", 64'(cmd_cnt - c0), 64'd0);
        rpulse(d, oe);
        chk("R6 R11 no drive deselected", 64'(oe), 64'd0);
        chk("R11 col kept", 64'(col), 64'd0);
        ce_n = 1'b0; idle(4);
    endtask

    task automatic t_busy();
        logic [BUS_W-1:0] d;
        logic oe;
        int w0;
        busy_len = 0;
        wcycle(1'b1, 1'b0, 16'h0030);
        chk("R7 busy entered", 64'(rb_n), 64'd0);
        w0 = wr_cnt;
        wcycle(1'b0, 1'b0, 16'h1234);
        chk("R8 data ignored", 64'(wr_cnt - w0), 64'd0);
        rpulse(d, oe);
        chk("R8 read ignored oe", 64'(oe), 64'd0);
        chk("R8 read ignored col", 64'(col), 64'd0);
        ce_n = 1'b1;
        wait_ready();
        idle(2);
        chk("R7 R8 busy length", 64'(busy_len), 64'(BUSY));
        rpulse(d, oe);
        chk("R8 standby after busy", 64'(oe), 64'd0);
        ce_n = 1'b0; idle(4);
    endtask

    task automatic t_wp();
        int c0 = cmd_cnt;
        wp_n = 1'b0; idle(4);
        busy_len = 0;
        wcycle(1'b1, 1'b0, 16'h0010);
        wcycle(1'b1, 1'b0, 16'h00D0);
        chk("R9 prog erase dropped", 64'(cmd_cnt - c0), 64'd0);
        chk("R9 no busy", 64'(busy_len), 64'd0);
        wcycle(1'b1, 1'b0, 16'h0030);
        chk("R9 read start allowed", 64'(rb_n), 64'd0);
        wait_ready();
        wp_n = 1'b1; idle(4);
        busy_len = 0;
        wcycle(1'b1, 1'b0, 16'h0010);
        chk("R9 prog when unprotected", 64'(cmd_code), 64'h10);
        wait_ready();
        idle(2);
        chk("R7 prog busy length", 64'(busy_len), 64'(BUSY));
    endtask

    task automatic t_proto();
        int c0 = cmd_cnt;
        int w0 = wr_cnt;
        logic [8*NB-1:0] a0 = addr;
        wcycle(1'b1, 1'b1, 16'h0099);
        chk("R10 flag set", 64'(proto_err), 64'd1);
        chk("R10 addr kept", 64'(addr), 64'(a0));
        chk("R10 no strobe", 64'(cmd_cnt - c0 + wr_cnt - w0), 64'd0);
        wcycle(1'b1, 1'b0, 16'h0000);
        chk("R10 flag sticky", 64'(proto_err), 64'd1);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(3);
        t_reset();
        t_cmd();
        t_addr();
        t_data();
        t_read();
        t_deselect();
        t_busy();
        t_wp();
        t_proto();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule